// File: doc/BRIEF.md
# Interval Queue Occupancy Monitor

This block measures how full one clock domain's input queue runs over a fixed amount of work. It frames sampling intervals by counting retired instructions rather than clock cycles. On every clock cycle of an interval it adds the queue's current count of valid entries into a saturating accumulator. A second saturating counter tallies the interval's cycles alongside it. When the retired-instruction count reaches the interval length, both totals are captured into output registers and a one-cycle strobe tells the downstream frequency controller that a fresh sample is ready. The counters then restart for the next interval. The controller can compute interval IPC as interval length over cycle count, and average occupancy as occupancy sum over cycle count.

The retire input carries 0 to `MAX_RETIRE` instructions per cycle. When a cycle's retirements carry the running count to or past the interval length, the interval closes on that cycle and the excess instructions are dropped. The occupancy seen in the closing cycle opens the next interval. Clock-domain crossing and the frequency decision are left to other blocks.

Top module: `occ_interval_monitor`

## Requirements
- R1: While `rst` is high at a rising edge, `sample_valid`, `occ_sum` and `cyc_count` are 0 after that edge, and all interval state restarts. The first cycle with `rst` low is the first cycle of a new interval.
- R2: An interval closes on the cycle in which the retired count, including that cycle's `retire_cnt`, reaches or passes `INTERVAL_LEN` (default 10000). `sample_valid` is high for the one cycle after each closing cycle and low after every other cycle.
- R3: On each strobe, `occ_sum` equals the sum of `q_occupancy` over the interval's cycles. These run from the previous closing cycle, or from the first cycle after reset, up to but not including the current closing cycle.
- R4: The occupancy sum saturates at all ones (2^`SUM_W`-1, default 65535) instead of wrapping. A sum larger than queue depth times interval length is a legal result.
- R5: On each strobe, `cyc_count` equals the number of cycles whose occupancy went into `occ_sum`. It saturates at 2^`CYC_W`-1.
- R6: Instructions retired beyond `INTERVAL_LEN` in the closing cycle are discarded. The next interval counts from zero.
- R7: Between strobes, `occ_sum` and `cyc_count` hold their last captured values.
- R8: Cycles with `retire_cnt` equal to 0 lengthen the interval. Their occupancy is still accumulated and they still count as cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_cnt | input | RET_W (bits to hold MAX_RETIRE) | Instructions retired this cycle, 0 to MAX_RETIRE |
| q_occupancy | input | OCC_W | Valid entries in the monitored queue this cycle |
| occ_sum | output | SUM_W | Captured occupancy sum of the last interval |
| cyc_count | output | CYC_W | Captured cycle count of the last interval |
| sample_valid | output | 1 | One-cycle strobe marking a new capture |

## Verification
The bench builds the monitor with an interval of 20 instructions, a 5-bit occupancy input, an 8-bit sum and a 5-bit cycle counter. The short interval lets many closings be observed within a few hundred cycles, including a closing that overshoots by two instructions. The narrow sum lets it saturate within a dozen cycles at full occupancy. The narrow cycle counter saturates during a long stretch of zero-retire cycles. A reference model updated from the requirements predicts every cycle's strobe and the captured values. Directed scenarios also check the cycle counts that expose carried-over instructions and stall cycles.

// File: rtl/occ_mon_pkg.sv
package occ_mon_pkg;

  // Number of bits needed to hold values 0..v.
  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 1) ? 1 : $clog2(v + 1);
  endfunction

  // Defaults used by the top level.
  localparam int unsigned DEF_INTERVAL_LEN = 10000;
  localparam int unsigned DEF_MAX_RETIRE   = 4;
  localparam int unsigned DEF_OCC_W        = 6;
  localparam int unsigned DEF_SUM_W        = 16;
  localparam int unsigned DEF_CYC_W        = 16;

endpackage

// File: rtl/omon_sat_counter.sv
// Saturating accumulator with a restart-and-load path.
module omon_sat_counter #(
  parameter int unsigned W     = 16,
  parameter int unsigned INC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt
);

  localparam int unsigned EW = W + 1;

  logic [EW-1:0] wide;

  assign wide = {1'b0, cnt} + EW'(inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart) begin
      // The closing cycle's increment opens the new interval.
      cnt <= W'(inc);
    end else if (wide[W]) begin
      cnt <= '1;
    end else begin
      cnt <= wide[W-1:0];
    end
  end

endmodule

// File: rtl/omon_interval_framer.sv
// Counts retired instructions and flags the cycle that closes an interval.
module omon_interval_framer #(
  parameter int unsigned LEN   = 10000,
  parameter int unsigned CNT_W = 14,
  parameter int unsigned RET_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RET_W-1:0] retire,
  output logic             iv_end,
  output logic [CNT_W-1:0] instr_cnt
);

  localparam int unsigned SW = CNT_W + 1;
  localparam logic [SW-1:0] LIMIT = SW'(LEN);

  logic [SW-1:0] nxt;

  assign nxt = {1'b0, instr_cnt} + SW'(retire);

  always_comb begin
    iv_end = (nxt >= LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_cnt <= '0;
    end else if (iv_end) begin
      // Excess retirements in the closing cycle are dropped.
      instr_cnt <= '0;
    end else begin
      instr_cnt <= nxt[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/omon_sample_reg.sv
// Output capture registers and the sample strobe.
module omon_sample_reg #(
  parameter int unsigned SUM_W = 16,
  parameter int unsigned CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SUM_W-1:0] sum_in,
  input  logic [CYC_W-1:0] cyc_in,
  output logic [SUM_W-1:0] sum_out,
  output logic [CYC_W-1:0] cyc_out,
  output logic             strobe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out <= '0;
      cyc_out <= '0;
      strobe  <= 1'b0;
    end else begin
      strobe <= load;
      if (load) begin
        sum_out <= sum_in;
        cyc_out <= cyc_in;
      end
    end
  end

endmodule

// File: rtl/occ_interval_monitor.sv
module occ_interval_monitor #(
  parameter int unsigned INTERVAL_LEN = occ_mon_pkg::DEF_INTERVAL_LEN,
  parameter int unsigned MAX_RETIRE   = occ_mon_pkg::DEF_MAX_RETIRE,
  parameter int unsigned OCC_W        = occ_mon_pkg::DEF_OCC_W,
  parameter int unsigned SUM_W        = occ_mon_pkg::DEF_SUM_W,
  parameter int unsigned CYC_W        = occ_mon_pkg::DEF_CYC_W,
  localparam int unsigned RET_W       = occ_mon_pkg::bits_for(MAX_RETIRE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RET_W-1:0] retire_cnt,
  input  logic [OCC_W-1:0] q_occupancy,
  output logic [SUM_W-1:0] occ_sum,
  output logic [CYC_W-1:0] cyc_count,
  output logic             sample_valid
);

  localparam int unsigned CNT_W = occ_mon_pkg::bits_for(INTERVAL_LEN);

  logic             iv_end;
  logic [CNT_W-1:0] instr_cnt;
  logic [SUM_W-1:0] acc_q;
  logic [CYC_W-1:0] cyc_q;

  omon_interval_framer #(
    .LEN  (INTERVAL_LEN),
    .CNT_W(CNT_W),
    .RET_W(RET_W)
  ) u_framer (
    .clk      (clk),
    .rst      (rst),
    .retire   (retire_cnt),
    .iv_end   (iv_end),
    .instr_cnt(instr_cnt)
  );

  omon_sat_counter #(
    .W    (SUM_W),
    .INC_W(OCC_W)
  ) u_occ_acc (
    .clk    (clk),
    .rst    (rst),
    .restart(iv_end),
    .inc    (q_occupancy),
    .cnt    (acc_q)
  );

  omon_sat_counter #(
    .W    (CYC_W),
    .INC_W(1)
  ) u_cyc_acc (
    .clk    (clk),
    .rst    (rst),
    .restart(iv_end),
    .inc    (1'b1),
    .cnt    (cyc_q)
  );

  omon_sample_reg #(
    .SUM_W(SUM_W),
    .CYC_W(CYC_W)
  ) u_capture (
    .clk    (clk),
    .rst    (rst),
    .load   (iv_end),
    .sum_in (acc_q),
    .cyc_in (cyc_q),
    .sum_out(occ_sum),
    .cyc_out(cyc_count),
    .strobe (sample_valid)
  );

endmodule

// File: rtl/omon_checker.sv
module omon_checker #(
  parameter int unsigned OCC_W = 6,
  parameter int unsigned CNT_W = 14,
  parameter int unsigned SUM_W = 16,
  parameter int unsigned CYC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             iv_end,
  input logic [CNT_W-1:0] instr_cnt,
  input logic [SUM_W-1:0] acc_q,
  input logic [CYC_W-1:0] cyc_q,
  input logic [OCC_W-1:0] q_occupancy,
  input logic [SUM_W-1:0] occ_sum,
  input logic [CYC_W-1:0] cyc_count,
  input logic             sample_valid
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!sample_valid && occ_sum == '0 && cyc_count == '0));

  p_strobe_on_end_r2: assert property (@(posedge clk) disable iff (rst)
    iv_end |=> sample_valid);

  p_strobe_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !iv_end |=> !sample_valid);

  p_acc_reopen_r3: assert property (@(posedge clk) disable iff (rst)
    iv_end |=> (acc_q == SUM_W'($past(q_occupancy))));

  p_acc_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    !iv_end |=> (acc_q >= $past(acc_q)));

  p_cyc_reopen_r5: assert property (@(posedge clk) disable iff (rst)
    iv_end |=> (cyc_q == CYC_W'(1)));

  p_instr_restart_r6: assert property (@(posedge clk) disable iff (rst)
    iv_end |=> (instr_cnt == '0));

  p_hold_between_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !sample_valid) |-> ($stable(occ_sum) && $stable(cyc_count)));

endmodule

bind occ_interval_monitor omon_checker #(
  .OCC_W(OCC_W),
  .CNT_W(CNT_W),
  .SUM_W(SUM_W),
  .CYC_W(CYC_W)
) u_omon_checker (
  .clk         (clk),
  .rst         (rst),
  .iv_end      (iv_end),
  .instr_cnt   (instr_cnt),
  .acc_q       (acc_q),
  .cyc_q       (cyc_q),
  .q_occupancy (q_occupancy),
  .occ_sum     (occ_sum),
  .cyc_count   (cyc_count),
  .sample_valid(sample_valid)
);

// File: tb/test_occ_interval_monitor.sv
`timescale 1ns/1ps
module test_occ_interval_monitor;

  localparam int LEN     = 20;
  localparam int OCC_W   = 5;
  localparam int SUM_W   = 8;
  localparam int CYC_W   = 5;
  localparam int SUM_MAX = (1 << SUM_W) - 1;
  localparam int CYC_MAX = (1 << CYC_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       retire_cnt = '0;
  logic [OCC_W-1:0] q_occupancy = '0;
  logic [SUM_W-1:0] occ_sum;
  logic [CYC_W-1:0] cyc_count;
  logic             sample_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int m_acc = 0, m_cyc = 0, m_cnt = 0;
  int e_sum = 0, e_cyc = 0;
  bit e_valid = 1'b0;
  bit e_sat   = 1'b0;
  bit m_sat   = 1'b0;

  always #10 clk = ~clk;

  occ_interval_monitor #(
    .INTERVAL_LEN(LEN),
    .MAX_RETIRE  (4),
    .OCC_W       (OCC_W),
    .SUM_W       (SUM_W),
    .CYC_W       (CYC_W)
  ) i_occ_interval_monitor (
    .clk         (clk),
    .rst         (rst),
    .retire_cnt  (retire_cnt),
    .q_occupancy (q_occupancy),
    .occ_sum     (occ_sum),
    .cyc_count   (cyc_count),
    .sample_valid(sample_valid)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock: drive inputs, let the edge pass, update model, compare.
  task automatic step(input bit r, input int ret, input int occ);
    rst         = r;
    retire_cnt  = 3'(ret);
    q_occupancy = OCC_W'(occ);
    @(posedge clk);
    #2;
    if (r) begin
      m_acc = 0; m_cyc = 0; m_cnt = 0; m_sat = 0;
      e_valid = 0; e_sum = 0; e_cyc = 0; e_sat = 0;
      check("R1", "reset strobe", int'(sample_valid), 0);
      check("R1", "reset sum", int'(occ_sum), 0);
      check("R1", "reset cycles", int'(cyc_count), 0);
      return;
    end
    if (m_cnt + ret >= LEN) begin
      e_valid = 1; e_sum = m_acc; e_cyc = m_cyc; e_sat = m_sat;
      m_acc = occ; m_cyc = 1; m_cnt = 0; m_sat = 0;
    end else begin
      e_valid = 0;
      m_acc = m_acc + occ;
      if (m_acc > SUM_MAX) begin m_acc = SUM_MAX; m_sat = 1; end
      m_cyc = (m_cyc + 1 > CYC_MAX) ? CYC_MAX : m_cyc + 1;
      m_cnt = m_cnt + ret;
    end
    check("R2", "strobe", int'(sample_valid), int'(e_valid));
    if (e_valid) begin
      check(e_sat ? "R4" : "R3", "captured sum", int'(occ_sum), e_sum);
      check("R5", "captured cycles", int'(cyc_count), e_cyc);
    end else begin
      check("R7", "held sum", int'(occ_sum), e_sum);
      check("R7", "held cycles", int'(cyc_count), e_cyc);
    end
  endtask

  task automatic do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, 3, 7);
  endtask

  task automatic t_reset_r1();
    do_reset();
    for (int i = 0; i < 20; i++) step(1'b0, 1, 2);
    check("R1", "first interval sum", int'(occ_sum), 38);
    check("R1", "first interval cycles", int'(cyc_count), 19);
  endtask

  task automatic t_steady_r3();
    do_reset();
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < 20; i++) step(1'b0, 1, k + 3);
    check("R3", "third interval sum", int'(occ_sum), 4 * 1 + 5 * 19);
  endtask

  task automatic t_overshoot_r6();
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b0, 3, 1);
    step(1'b0, 4, 1);
    check("R2", "overshoot closes interval", int'(sample_valid), 1);
    for (int i = 0; i < 7; i++) step(1'b0, 3, 2);
    check("R6", "excess dropped, strobe after 7", int'(sample_valid), 1);
    check("R6", "cycles of next interval", int'(cyc_count), 7);
    check("R6", "sum of next interval", int'(occ_sum), 1 + 6 * 2);
  endtask

  task automatic t_stall_r8();
    do_reset();
    for (int i = 0; i < 20; i++) step(1'b0, (i % 2) ? 2 : 0, 1);
    check("R8", "stall cycles counted", int'(cyc_count), 19);
    check("R8", "stall occupancy counted", int'(occ_sum), 19);
  endtask

  task automatic t_saturate_r4_r5();
    do_reset();
    for (int i = 0; i < 20; i++) step(1'b0, 1, 31);
    check("R4", "sum saturates", int'(occ_sum), SUM_MAX);
    for (int i = 0; i < 40; i++) step(1'b0, 0, 0);
    for (int i = 0; i < 5; i++) step(1'b0, 4, 0);
    check("R5", "cycles saturate", int'(cyc_count), CYC_MAX);
  endtask

  task automatic t_mid_reset_r1();
    do_reset();
    for (int i = 0; i < 20; i++) step(1'b0, 1, 4);
    for (int i = 0; i < 10; i++) step(1'b0, 1, 9);
    step(1'b1, 1, 9);
    step(1'b1, 1, 9);
    for (int i = 0; i < 20; i++) step(1'b0, 1, 2);
    check("R1", "fresh interval after reset", int'(occ_sum), 38);
  endtask

  initial begin
    t_reset_r1();
    t_steady_r3();
    t_overshoot_r6();
    t_stall_r8();
    t_saturate_r4_r5();
    t_mid_reset_r1();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run got %0d cycles expected finish", 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule